// File: doc/BRIEF.md
# Host Mailbox Register Interface

This block is the device-side end of a byte-wide parallel host port in front of a coprocessor. The host sees two byte registers. A message register is shared by both directions: a write to it carries a control byte inward, and a read returns the newest response byte. A status register reports whether the inward byte is still waiting to be taken, whether an unread response byte is present, and whether a write was lost. The host is expected to poll the status register before each transfer.

On the internal side, the block offers the pending inbound byte as a valid/ready stream and accepts response bytes through a second valid/ready stream. In run-time mode responses come in 6-byte messages, and an active-low interrupt line tells the host that a message is waiting. In boot mode the exchange is a fixed handshake: three bytes go in, then one response byte comes out, and the interrupt line stays inactive.

Top module: `hostmbox`

## Requirements
- R1: After reset the status register reads 0x00, `irq_n` is 1, `in_valid` is 0, the message register reads 0x00, and `out_ready` is 1 when `boot_mode` is 0.
- R2: A host write with `hs_addr`=00 while status bit 0 is 0 makes `in_valid` and status bit 0 go to 1 in the next cycle, with `in_data` equal to the written byte. Both return to 0 in the cycle after a cycle with `in_valid` and `in_ready` both high.
- R3: A host write with `hs_addr`=00 while status bit 0 is 1 is ignored: `in_data` keeps the earlier byte. Status bit 7 goes to 1 in the next cycle and stays at 1 until the host reads the status register (`hs_addr`=01). It is 0 in the cycle after that read.
- R4: `out_ready` is high only while status bit 1 is 0, and in boot mode only under R9 as well. A byte accepted on the outbound stream sets status bit 1 in the next cycle and is then returned by reads with `hs_addr`=00.
- R5: A host read with `hs_addr`=00 while status bit 1 is 1 clears status bit 1 in the next cycle. Such a read while bit 1 is 0 changes nothing.
- R6: The status register layout is bit 0 input-busy, bit 1 output-ready, bit 7 overrun, and the other bits are 0. Addresses 10 and 11 read 0x00, and writes to them have no effect.
- R7: In run-time mode, `irq_n` goes low in the cycle after the outbound stream accepts the first byte of a message. It returns high in the cycle after the host has read all 6 bytes of that message.
- R8: While `boot_mode` is 1, `irq_n` is 1, and the run-time message byte count restarts.
- R9: In boot mode, `out_ready` stays low until 3 inbound bytes have been accepted on the internal side since boot began or since the previous response byte. Each accepted response byte restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode | input | 1 | 1 selects the boot handshake, 0 selects run-time mode |
| hs_addr | input | 2 | Host register select: 00 message, 01 status |
| hs_wr | input | 1 | Host write strobe, one cycle per byte |
| hs_rd | input | 1 | Host read strobe, one cycle per byte |
| hs_wdata | input | 8 | Host write data |
| hs_rdata | output | 8 | Host read data for the selected register |
| irq_n | output | 1 | Active-low outgoing-message request |
| in_valid | output | 1 | Inbound byte available to the internal side |
| in_data | output | 8 | Inbound byte |
| in_ready | input | 1 | Internal side takes the inbound byte |
| out_valid | input | 1 | Internal side offers a response byte |
| out_data | input | 8 | Response byte |
| out_ready | output | 1 | Block can take a response byte |

## Verification
Embedded assertions check the single-step rules on every cycle. An accepted write raises busy with the written byte, a write while busy sets overrun and leaves the byte alone, a message read clears output-ready, an outbound acceptance fills the register, and the sixth read releases the interrupt. Longer behaviours can only be seen through the bench's behavioural model over random traffic in both modes. These include the boot gate that waits for three inbound bytes, overrun staying set until a status read, the interrupt spanning a whole 6-byte message, and the reads of unused addresses.

// File: rtl/hostmbox.sv
module hostmbox #(
  parameter int DW      = 8,
  parameter int MSG_LEN = 6,
  parameter int BOOT_IN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_mode,
  input  logic [1:0]    hs_addr,
  input  logic          hs_wr,
  input  logic          hs_rd,
  input  logic [DW-1:0] hs_wdata,
  output logic [DW-1:0] hs_rdata,
  output logic          irq_n,
  output logic          in_valid,
  output logic [DW-1:0] in_data,
  input  logic          in_ready,
  input  logic          out_valid,
  input  logic [DW-1:0] out_data,
  output logic          out_ready
);
  localparam int MW = $clog2(MSG_LEN + 1);
  localparam int BW = $clog2(BOOT_IN + 1);

  logic [DW-1:0] ib_q, ob_q;
  logic          ib_busy, ob_full, ovr, msg_on;
  logic [MW-1:0] rd_cnt;
  logic [BW-1:0] bt_cnt;

  wire sel_msg   = (hs_addr == 2'b00);
  wire sel_st    = (hs_addr == 2'b01);
  wire h_wr      = hs_wr && sel_msg;
  wire h_rd      = hs_rd && sel_msg && ob_full;
  wire st_rd     = hs_rd && sel_st;
  wire in_acc    = ib_busy && in_ready;
  wire boot_done = (bt_cnt == BW'(BOOT_IN));
  wire out_acc   = out_valid && out_ready;
  wire last_rd   = h_rd && !boot_mode && (rd_cnt == MW'(MSG_LEN - 1));

  wire [DW-1:0] status = {ovr, {(DW-3){1'b0}}, ob_full, ib_busy};

  assign out_ready = !ob_full && (!boot_mode || boot_done);
  assign in_valid  = ib_busy;
  assign in_data   = ib_q;
  assign irq_n     = !(msg_on && !boot_mode);
  assign hs_rdata  = sel_msg ? ob_q : (sel_st ? status : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ib_q    <= '0;
      ib_busy <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (h_wr && ib_busy)   ovr <= 1'b1;
      else if (st_rd)        ovr <= 1'b0;
      if (h_wr && !ib_busy) begin
        ib_q    <= hs_wdata;
        ib_busy <= 1'b1;
      end else if (in_acc) begin
        ib_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_q    <= '0;
      ob_full <= 1'b0;
    end else if (out_acc) begin
      ob_q    <= out_data;
      ob_full <= 1'b1;
    end else if (h_rd) begin
      ob_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || boot_mode) begin
      rd_cnt <= '0;
      msg_on <= 1'b0;
    end else if (last_rd) begin
      rd_cnt <= '0;
      msg_on <= 1'b0;
    end else begin
      if (h_rd)    rd_cnt <= rd_cnt + 1'b1;
      if (out_acc) msg_on <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !boot_mode)        bt_cnt <= '0;
    else if (out_acc)                bt_cnt <= '0;
    else if (in_acc && !boot_done)   bt_cnt <= bt_cnt + 1'b1;
  end

  assert_wr_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !ib_busy) |=> (in_valid && in_data == $past(hs_wdata)));

  assert_busy_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && ib_busy) |=> (hs_rdata[DW-1] || !sel_st) && ovr && $stable(in_data));

  assert_out_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_acc |=> (ob_full && ob_q == $past(out_data)));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd |=> !ob_full);

  assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_rd |=> irq_n);
endmodule

// File: tb/hostmbox_tb_top.sv
`timescale 1ns/1ps
module hostmbox_tb_top;
  logic clk = 0, rst_n = 0, boot_mode = 0;
  logic [1:0] hs_addr = 0;
  logic hs_wr = 0, hs_rd = 0, in_ready = 0, out_valid = 0;
  logic [7:0] hs_wdata = 0, out_data = 0;
  logic [7:0] hs_rdata, in_data;
  logic irq_n, in_valid, out_ready;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  hostmbox dut_i (.clk, .rst_n, .boot_mode, .hs_addr, .hs_wr, .hs_rd, .hs_wdata,
    .hs_rdata, .irq_n, .in_valid, .in_data, .in_ready, .out_valid, .out_data, .out_ready);

  byte unsigned q_in[$], q_out[$];
  byte unsigned last_out = 0;
  bit m_ovr = 0, m_msg = 0;
  int m_reads = 0, m_boot_in = 0;

  function automatic bit m_oready();
    return q_out.size() == 0 && (!boot_mode || m_boot_in == 3);
  endfunction

  function automatic byte unsigned m_status();
    return {m_ovr, 5'b0, q_out.size() != 0, q_in.size() != 0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_in.delete(); q_out.delete(); last_out = 0;
      m_ovr = 0; m_msg = 0; m_reads = 0; m_boot_in = 0;
    end else begin
      bit busy, full, ordy;
      busy = q_in.size() != 0;
      full = q_out.size() != 0;
      ordy = m_oready();
      if (busy && in_ready) begin
        void'(q_in.pop_front());
        if (boot_mode && m_boot_in < 3) m_boot_in++;
      end
      if (hs_wr && hs_addr == 0) begin
        if (busy) m_ovr = 1; else q_in.push_back(hs_wdata);
      end
      if (hs_rd && hs_addr == 1 && !(hs_wr && hs_addr == 0 && busy)) m_ovr = 0;
      if (hs_rd && hs_addr == 0 && full) begin
        void'(q_out.pop_front());
        if (!boot_mode) begin
          m_reads++;
          if (m_reads == 6) begin m_reads = 0; m_msg = 0; end
        end
      end
      if (out_valid && ordy) begin
        q_out.push_back(out_data); last_out = out_data;
        if (boot_mode) m_boot_in = 0; else m_msg = 1;
      end
      if (boot_mode) begin m_reads = 0; m_msg = 0; end
      else m_boot_in = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    byte unsigned st;
    st = m_status();
    check(boot_mode ? "R9 out_ready" : "R4 out_ready", out_ready, m_oready());
    check(boot_mode ? "R8 irq_n" : "R7 irq_n", irq_n, !(m_msg && !boot_mode));
    check("R2 in_valid", in_valid, q_in.size() != 0);
    if (q_in.size() != 0) check("R2 in_data", in_data, q_in[0]);
    case (hs_addr)
      2'd0: check("R4 message read", hs_rdata, last_out);
      2'd1: begin
        check("R2 status bit0", hs_rdata[0], st[0]);
        check("R5 status bit1", hs_rdata[1], st[1]);
        check("R3 status bit7", hs_rdata[7], st[7]);
        check("R6 status zero bits", hs_rdata[6:2], 0);
      end
      default: check("R6 unused address", hs_rdata, 0);
    endcase
  end

  task automatic rand_cycle(int wr_pct, int rd_pct);
    int r;
    @(posedge clk); #1;
    r = $urandom_range(99);
    hs_wr = r < wr_pct;
    hs_rd = !hs_wr && r < wr_pct + rd_pct;
    hs_addr = ($urandom_range(9) < 8) ? 2'($urandom_range(1)) : 2'($urandom_range(3));
    hs_wdata = 8'($urandom);
    in_ready = $urandom_range(2) != 0;
    out_valid = $urandom_range(1) != 0;
    out_data = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    hs_addr = 1;
    #0;
    check("R1 status after reset", hs_rdata, 0);
    check("R1 irq_n after reset", irq_n, 1);
    check("R1 in_valid after reset", in_valid, 0);
    check("R1 out_ready after reset", out_ready, 1);
    hs_addr = 0;
    #0;
    check("R1 message after reset", hs_rdata, 0);
    repeat (4000) rand_cycle(25, 30);
    @(posedge clk); #1 boot_mode = 1; hs_wr = 0; hs_rd = 0; out_valid = 0;
    repeat (4000) rand_cycle(30, 25);
    @(posedge clk); #1 boot_mode = 0;
    repeat (3000) rand_cycle(20, 35);
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1; hs_wr = 0; hs_rd = 0; out_valid = 0; in_ready = 0;
    repeat (2000) rand_cycle(40, 40);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule